// File: doc/BRIEF.md
# CAN Transceiver Mode and Protection Controller

This block is the digital core of a high-speed CAN line driver. It takes the transmit bit from the protocol controller, a listen-only select, a chip enable and the digitised output of the bus comparator, together with over-temperature and supply-undervoltage flags from the analog side. From these it commands the bus output stage through a driver-enable and a drive-dominant signal, and it returns the received bit with its own output-enable.

Three operating modes are supported: off (everything floats), normal (transmit and receive) and listen-only (receive only, driver held recessive). Three protection mechanisms sit between the transmit input and the driver. A dominant-timeout counter stops a stuck-low transmit input from blocking the bus. A thermal latch holds the driver off until the die has cooled and the transmit input has returned high. An undervoltage latch works the same way for a supply fault. All asynchronous inputs pass through a two-flop synchroniser. The reset values of the synchroniser match the levels of undriven pins: transmit high, select and enable low.

Top module: `can_phy_ctrl`

## Requirements
- R1: The mode decode is as follows: enable low gives off whatever the other inputs are; enable high with listen-only low gives normal; enable high with listen-only high gives listen-only. The encoding on `mode_o` is 0 for off, 1 for normal and 2 for listen-only.
- R2: In normal mode, `drv_en_o` is 1 and `drv_dom_o` is the inverse of the transmit input, so low means dominant. `rxd_oe_o` is 1 and `rxd_o` is the inverse of `bus_dom_i`, where 1 means the bus is dominant.
- R3: In listen-only mode, `drv_en_o` is 1 and `drv_dom_o` is 0 for any transmit value. `rxd_o` still goes low while another node holds the bus dominant.
- R4: In off mode, `drv_en_o`, `drv_dom_o` and `rxd_oe_o` are all 0, and `rxd_o` rests at 1.
- R5: Once the synchronised transmit input has been low for more than TMO_CYC clock cycles after its falling edge, `drv_dom_o` is forced to 0 and `tmo_flag_o` is set. The flag is sticky while the input stays low.
- R6: The cycle after a synchronised rising edge of the transmit input, the timeout count and `tmo_flag_o` are cleared. A low pulse shorter than the limit never trips the timeout, and every new falling edge restarts the count.
- R7: A high `otemp_i` sets `tsd_flag_o` and forces `drv_dom_o` to 0. The receive path and the mode decode keep working meanwhile. The latch releases only on a cycle in which the over-temperature flag is clear and the transmit input is high.
- R8: A high `uvolt_i` forces `drv_dom_o` to 0 without changing `drv_en_o`. Driving resumes only after the flag has cleared and the transmit input has been seen high.
- R9: Each input reaches the outputs two clock cycles after it changes, and the protection latches add one more cycle. During reset the block reads transmit high and enable and listen-only low. It therefore reports off mode with all outputs disabled, whatever the input pins show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit bit from the protocol controller, low = dominant |
| silent_i | input | 1 | Listen-only select, high = listen-only |
| enable_i | input | 1 | Chip enable, low = off |
| bus_dom_i | input | 1 | Bus comparator result, high = bus dominant |
| otemp_i | input | 1 | Over-temperature flag from the sensor |
| uvolt_i | input | 1 | Supply undervoltage flag |
| drv_en_o | output | 1 | Bus output stage enable, low = lines float |
| drv_dom_o | output | 1 | Drive the bus dominant |
| rxd_o | output | 1 | Received bit, low = bus dominant |
| rxd_oe_o | output | 1 | Receive output enable, low = floating |
| tmo_flag_o | output | 1 | Dominant timeout active |
| tsd_flag_o | output | 1 | Thermal shutdown latched |
| mode_o | output | 2 | Current mode: 0 off, 1 normal, 2 listen-only |

## Verification
The mode outputs, the driver command and the received bit are due two clock edges after an input changes. The thermal and undervoltage latches settle on the third edge. The timeout flag rises on edge TMO_CYC+3 after the transmit input falls and clears on the third edge after it rises. The bench drives inputs on a falling clock edge and counts falling edges before it samples, so every check lands either on the first cycle a result is due or on the last cycle before it. The timeout and latch-release checks sample both sides of the boundary edge, which shows that the change happens on that edge and on no other.

// File: rtl/can_phy_pkg.sv
package can_phy_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_SILENT = 2'd2
  } phy_mode_e;

  // synchronised input vector layout
  localparam int IX_TXD  = 0;
  localparam int IX_SIL  = 1;
  localparam int IX_EN   = 2;
  localparam int IX_BUS  = 3;
  localparam int IX_OT   = 4;
  localparam int IX_UV   = 5;
  localparam int IN_W    = 6;

  // reset values mirror the levels of undriven pins
  localparam logic [IN_W-1:0] IN_RST = 6'b00_0001;

  // latched fault sources
  localparam int FLT_OT  = 0;
  localparam int FLT_UV  = 1;
  localparam int FLT_N   = 2;

endpackage

// File: rtl/can_phy_sync.sv
module can_phy_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_VAL;
      else        stg_q[g] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/can_phy_dom_timer.sv
module can_phy_dom_timer #(
  parameter int TMO_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_s,
  output logic tmo_o
);

  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC);

  logic          txd_d_q;
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q,   cnt_d;
  logic          tmo_q,   tmo_d;
  logic          fall, rise;

  assign fall = txd_d_q & ~txd_s;
  assign rise = ~txd_d_q & txd_s;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    tmo_d   = tmo_q;
    if (rise) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      tmo_d   = 1'b0;
    end else if (fall) begin
      armed_d = 1'b1;
      cnt_d   = CW'(1);
    end else if (armed_q && !tmo_q) begin
      if (cnt_q == LIMIT) tmo_d = 1'b1;
      else                cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_d_q <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      tmo_q   <= 1'b0;
    end else begin
      txd_d_q <= txd_s;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
    end
  end

  assign tmo_o = tmo_q;

endmodule

// File: rtl/can_phy_hold_latch.sv
module can_phy_hold_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_s,
  input  logic txd_s,
  output logic held_o
);

  logic held_q, held_d;

  // set by the fault, kept until fault gone and transmit input high
  always_comb begin
    held_d = held_q;
    if (flag_s)     held_d = 1'b1;
    else if (txd_s) held_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  assign held_o = held_q;

endmodule

// File: rtl/can_phy_outmux.sv
module can_phy_outmux
  import can_phy_pkg::*;
(
  input  logic      enable_s,
  input  logic      silent_s,
  input  logic      txd_s,
  input  logic      bus_dom_s,
  input  logic      tx_block,
  output phy_mode_e mode,
  output logic      drv_en,
  output logic      drv_dom,
  output logic      rxd,
  output logic      rxd_oe
);

  always_comb begin
    if (!enable_s)     mode = MODE_OFF;
    else if (silent_s) mode = MODE_SILENT;
    else               mode = MODE_NORMAL;
  end

  always_comb begin
    drv_en  = 1'b0;
    drv_dom = 1'b0;
    rxd     = 1'b1;
    rxd_oe  = 1'b0;
    unique case (mode)
      MODE_NORMAL: begin
        drv_en  = 1'b1;
        drv_dom = ~txd_s & ~tx_block;
        rxd     = ~bus_dom_s;
        rxd_oe  = 1'b1;
      end
      MODE_SILENT: begin
        drv_en  = 1'b1;
        rxd     = ~bus_dom_s;
        rxd_oe  = 1'b1;
      end
      default: begin
        drv_en  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/can_phy_ctrl.sv
module can_phy_ctrl
  import can_phy_pkg::*;
#(
  parameter int TMO_CYC = 50000,  // 2.5 ms at a 20 MHz core clock
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txd_i,
  input  logic       silent_i,
  input  logic       enable_i,
  input  logic       bus_dom_i,
  input  logic       otemp_i,
  input  logic       uvolt_i,
  output logic       drv_en_o,
  output logic       drv_dom_o,
  output logic       rxd_o,
  output logic       rxd_oe_o,
  output logic       tmo_flag_o,
  output logic       tsd_flag_o,
  output logic [1:0] mode_o
);

  logic [IN_W-1:0]  raw, syn;
  logic [FLT_N-1:0] flt_s, flt_held;
  logic             tmo;
  phy_mode_e        mode;

  always_comb begin
    raw         = '0;
    raw[IX_TXD] = txd_i;
    raw[IX_SIL] = silent_i;
    raw[IX_EN]  = enable_i;
    raw[IX_BUS] = bus_dom_i;
    raw[IX_OT]  = otemp_i;
    raw[IX_UV]  = uvolt_i;
  end

  can_phy_sync #(
    .W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  can_phy_dom_timer #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .txd_s(syn[IX_TXD]), .tmo_o(tmo)
  );

  assign flt_s[FLT_OT] = syn[IX_OT];
  assign flt_s[FLT_UV] = syn[IX_UV];

  for (genvar f = 0; f < FLT_N; f++) begin : g_flt
    can_phy_hold_latch u_hold (
      .clk(clk), .rst_n(rst_n), .flag_s(flt_s[f]),
      .txd_s(syn[IX_TXD]), .held_o(flt_held[f])
    );
  end

  can_phy_outmux u_out (
    .enable_s (syn[IX_EN]),
    .silent_s (syn[IX_SIL]),
    .txd_s    (syn[IX_TXD]),
    .bus_dom_s(syn[IX_BUS]),
    .tx_block (tmo | (|flt_held)),
    .mode     (mode),
    .drv_en   (drv_en_o),
    .drv_dom  (drv_dom_o),
    .rxd      (rxd_o),
    .rxd_oe   (rxd_oe_o)
  );

  assign mode_o     = mode;
  assign tmo_flag_o = tmo;
  assign tsd_flag_o = flt_held[FLT_OT];

endmodule

// File: rtl/can_phy_ctrl_chk.sv
module can_phy_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd_i,
  input logic       enable_i,
  input logic       bus_dom_i,
  input logic       otemp_i,
  input logic       uvolt_i,
  input logic       drv_en_o,
  input logic       drv_dom_o,
  input logic       rxd_o,
  input logic       rxd_oe_o,
  input logic       tmo_flag_o,
  input logic       tsd_flag_o,
  input logic [1:0] mode_o
);

  logic [1:0] up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            up_q <= 2'd0;
    else if (up_q != 2'd3) up_q <= up_q + 2'd1;
  end

  AST_OFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q >= 2'd2 && !$past(enable_i, 2)) |-> (!drv_en_o && !rxd_oe_o)); // R4

  AST_RXD_TRACKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q >= 2'd2 && rxd_oe_o) |-> (rxd_o == !$past(bus_dom_i, 2))); // R2

  AST_DOM_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    drv_dom_o |-> (mode_o == 2'd1 && drv_en_o)); // R3

  AST_TMO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag_o |-> !drv_dom_o); // R5

  AST_TMO_CLEAR_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd3 && $fell(tmo_flag_o)) |-> $past(txd_i, 3)); // R6

  AST_TSD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd3 && $fell(tsd_flag_o)) |-> ($past(txd_i, 3) && !$past(otemp_i, 3))); // R7

  AST_UV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd3 && $past(uvolt_i, 3)) |-> !drv_dom_o); // R8

endmodule

bind can_phy_ctrl can_phy_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd_i(txd_i), .enable_i(enable_i),
  .bus_dom_i(bus_dom_i), .otemp_i(otemp_i), .uvolt_i(uvolt_i),
  .drv_en_o(drv_en_o), .drv_dom_o(drv_dom_o), .rxd_o(rxd_o),
  .rxd_oe_o(rxd_oe_o), .tmo_flag_o(tmo_flag_o), .tsd_flag_o(tsd_flag_o),
  .mode_o(mode_o)
);

// File: tb/tb_can_phy_ctrl.sv
module tb_can_phy_ctrl;

  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, sil = 1'b0, en = 1'b1, bus = 1'b0, ot = 1'b0, uv = 1'b0;
  logic drv_en, drv_dom, rxd, rxd_oe, tmo_f, tsd_f;
  logic [1:0] mode;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_phy_ctrl #(.TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .silent_i(sil), .enable_i(en),
    .bus_dom_i(bus), .otemp_i(ot), .uvolt_i(uv), .drv_en_o(drv_en),
    .drv_dom_o(drv_dom), .rxd_o(rxd), .rxd_oe_o(rxd_oe),
    .tmo_flag_o(tmo_f), .tsd_flag_o(tsd_f), .mode_o(mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    waitn(3);
    chk("R9", "mode in reset", mode, 0);
    chk("R9", "drv_en in reset", drv_en, 0);
    chk("R9", "rxd_oe in reset", rxd_oe, 0);
    chk("R9", "rxd in reset", rxd, 1);
    chk("R9", "flags in reset", {tmo_f, tsd_f}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_normal();
    @(negedge clk); en = 1; sil = 0; txd = 1; bus = 0;
    waitn(2);
    chk("R1", "mode normal", mode, 1);
    chk("R2", "drv_en normal", drv_en, 1);
    chk("R2", "recessive on txd high", drv_dom, 0);
    chk("R2", "rxd idle", rxd, 1);
    chk("R2", "rxd_oe normal", rxd_oe, 1);
    txd = 0;
    waitn(2);
    chk("R2", "dominant on txd low", drv_dom, 1);
    bus = 1;
    waitn(2);
    chk("R2", "rxd low on dominant bus", rxd, 0);
    txd = 1; bus = 0;
    waitn(1);
    chk("R9", "one cycle after txd rise", drv_dom, 1);
    waitn(1);
    chk("R9", "two cycles after txd rise", drv_dom, 0);
    chk("R2", "rxd back high", rxd, 1);
  endtask

  task automatic t_silent();
    sil = 1; txd = 0; bus = 1;
    waitn(2);
    chk("R1", "mode silent", mode, 2);
    chk("R3", "drv_en silent", drv_en, 1);
    chk("R3", "no drive in silent", drv_dom, 0);
    chk("R3", "rxd follows bus in silent", rxd, 0);
    bus = 0;
    waitn(2);
    chk("R3", "rxd recessive in silent", rxd, 1);
    txd = 1; sil = 0;
    waitn(2);
  endtask

  task automatic t_off();
    en = 0; sil = 1; txd = 0; bus = 1;
    waitn(2);
    chk("R1", "mode off (sil=1)", mode, 0);
    chk("R4", "drv_en off", drv_en, 0);
    chk("R4", "drv_dom off", drv_dom, 0);
    chk("R4", "rxd_oe off", rxd_oe, 0);
    chk("R4", "rxd rest off", rxd, 1);
    sil = 0;
    waitn(2);
    chk("R1", "mode off (sil=0)", mode, 0);
    chk("R4", "drv_en off sil=0", drv_en, 0);
    en = 1; txd = 1; bus = 0;
    waitn(2);
    chk("R1", "back to normal", mode, 1);
  endtask

  task automatic t_timeout();
    txd = 0;
    waitn(TMO + 2);
    chk("R5", "still dominant at limit", drv_dom, 1);
    chk("R5", "no flag at limit", tmo_f, 0);
    waitn(1);
    chk("R5", "forced recessive past limit", drv_dom, 0);
    chk("R5", "timeout flag set", tmo_f, 1);
    waitn(5);
    chk("R5", "timeout flag sticky", tmo_f, 1);
    txd = 1;
    waitn(2);
    chk("R6", "flag kept until clear edge", tmo_f, 1);
    waitn(1);
    chk("R6", "flag cleared after rise", tmo_f, 0);
    txd = 0;
    waitn(2);
    chk("R6", "driving resumes", drv_dom, 1);
    txd = 1;
    waitn(3);
    txd = 0;
    waitn(TMO - 5);
    txd = 1;
    waitn(3);
    txd = 0;
    waitn(TMO - 5);
    chk("R6", "short pulses: still dominant", drv_dom, 1);
    chk("R6", "short pulses: no flag", tmo_f, 0);
    txd = 1;
    waitn(3);
  endtask

  task automatic t_thermal();
    txd = 0;
    waitn(2);
    ot = 1; bus = 1;
    waitn(3);
    chk("R7", "tsd flag set", tsd_f, 1);
    chk("R7", "driver off in tsd", drv_dom, 0);
    chk("R7", "receiver works in tsd", rxd, 0);
    chk("R7", "mode kept in tsd", mode, 1);
    ot = 0;
    waitn(4);
    chk("R7", "held while txd low", tsd_f, 1);
    chk("R7", "driver still off", drv_dom, 0);
    txd = 1; bus = 0;
    waitn(2);
    chk("R7", "not yet released", tsd_f, 1);
    waitn(1);
    chk("R7", "released on txd high", tsd_f, 0);
    ot = 1;
    waitn(3);
    chk("R7", "set with txd high", tsd_f, 1);
    waitn(4);
    chk("R7", "held while hot and txd high", tsd_f, 1);
    ot = 0;
    waitn(3);
    chk("R7", "released once cool", tsd_f, 0);
    txd = 0;
    waitn(2);
    chk("R7", "driving after release", drv_dom, 1);
    txd = 1;
    waitn(2);
  endtask

  task automatic t_uvolt();
    txd = 0;
    waitn(2);
    uv = 1;
    waitn(3);
    chk("R8", "driver off in uv", drv_dom, 0);
    chk("R8", "drv_en kept in uv", drv_en, 1);
    uv = 0;
    waitn(4);
    chk("R8", "held until txd high", drv_dom, 0);
    txd = 1;
    waitn(3);
    txd = 0;
    waitn(2);
    chk("R8", "driving resumes after uv", drv_dom, 1);
    txd = 1;
    waitn(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_normal();
    t_silent();
    t_off();
    t_timeout();
    t_thermal();
    t_uvolt();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

endmodule